// File: doc/BRIEF.md
# Parallel Boot Stream Loader

This block sits on the target processor and takes in a boot image that an external feeder presents one byte at a time on an 8-bit parallel port. Every byte moves under a four-phase handshake. The loader raises a flag output and waits for the feeder's ready line to go high. It then drops the flag and waits for ready to go low. Only then does it capture the data port. Ready crosses into the loader's clock domain through a two-flop synchronizer before any handshake decision uses it. Two bytes form one 16-bit word.

The loader parses the word stream in a fixed order. It first reads two words that hold the program entry point. After that it reads records of the form length, destination-high, destination-low, followed by `length` payload words. It writes each payload word to an external memory port at consecutive addresses. A record whose length is zero ends the stream. The loader then pulses a done output and keeps the 32-bit entry value on its output until the next reset.

Top module: `boot_stream_loader`

## Requirements
- R1: For each byte, the flag goes high, stays high until the synchronized ready is seen high, then goes low, and the byte on the data port is captured only after the synchronized ready is seen low.
- R2: A word is assembled big-end first: the first byte of a pair forms bits 15:8 and the second byte forms bits 7:0.
- R3: The first two words of the stream are kept as the entry value, the first word in bits 31:16 and the second in bits 15:0, and this value is on `entry_addr_o` when `load_done_o` pulses.
- R4: A record length of zero ends loading. `load_done_o` is high for exactly one cycle, no memory write occurs in that cycle or afterwards, and the flag stays low until reset.
- R5: A record with a non-zero length N causes exactly N memory writes, each with `mem_we_o` high for one cycle.
- R6: The first write address of a record is the low 20 bits of (destination-high word shifted left by 16) plus the destination-low word.
- R7: Each later payload word of the record goes to the previous address plus one, with the carry moving into the bits above bit 15.
- R8: Before each payload write, the loader holds the flag high and issues the write only after the synchronized ready is seen high.
- R9: After the last payload word of a record, the loader reads the next record length, so any number of records can follow one another.
- R10: A synchronous reset in the middle of a stream discards all progress, and the loader then reads the next bytes as the first entry word.
- R11: While reset is held, `boot_flag_o`, `mem_we_o` and `load_done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_rdy_i | input | 1 | Ready line from the feeder, asynchronous |
| boot_data_i | input | 8 | Parallel byte from the feeder |
| boot_flag_o | output | 1 | Handshake flag to the feeder |
| mem_we_o | output | 1 | One-cycle write strobe per payload word |
| mem_addr_o | output | 20 | Write address |
| mem_data_o | output | 16 | Write data |
| load_done_o | output | 1 | One-cycle pulse when a zero-length record ends the stream |
| entry_addr_o | output | 32 | Entry value read from the first two words |

## Verification
Most wrong internal states in this loader become visible at the ports within a few cycles of the next byte exchange. A byte-phase slip swaps or shifts the halves of every later word. A parser state error puts the whole remainder of the stream into the wrong field, so write addresses, write counts or the entry value go wrong, or done never arrives. A repeat-counter error shows up at the end of one record as one write too many or one too few. A handshake that does not wait for ready shows as a flag fall or a write strobe fewer than two synchronizer cycles after ready rises.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

    localparam int BL_BYTE_W  = 8;
    localparam int BL_WORD_W  = 2 * BL_BYTE_W;
    localparam int BL_ADDR_W  = 20;
    localparam int BL_ENTRY_W = 2 * BL_WORD_W;

    typedef logic [BL_BYTE_W-1:0] byte_t;
    typedef logic [BL_WORD_W-1:0] word_t;
    typedef logic [BL_ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_RAISE,
        HS_LOWER
    } hs_state_t;

    typedef enum logic [2:0] {
        PS_ENT_HI,
        PS_ENT_LO,
        PS_LEN,
        PS_DST_HI,
        PS_DST_LO,
        PS_DATA,
        PS_PRE_WR,
        PS_HALT
    } ps_state_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t data;
    } wr_req_t;

    function automatic word_t join_bytes(input byte_t hi, input byte_t lo);
        word_t w;
        w = {hi, {BL_BYTE_W{1'b0}}};
        w = w | {{BL_BYTE_W{1'b0}}, lo};
        return w;
    endfunction

    function automatic addr_t ext_addr(input word_t hi, input word_t lo);
        logic [2*BL_WORD_W-1:0] sum;
        sum = {hi, {BL_WORD_W{1'b0}}} + {{BL_WORD_W{1'b0}}, lo};
        return BL_ADDR_W'(sum);
    endfunction

endpackage

// File: rtl/bsl_sync.sv
module bsl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bsl_word_rx.sv
module bsl_word_rx
    import boot_ldr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  logic  rdy_s,
    input  byte_t din,
    output logic  flag,
    output logic  busy,
    output logic  word_vld,
    output word_t word
);
    hs_state_t st;
    logic      second;
    byte_t     hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= HS_IDLE;
            second   <= 1'b0;
            hi_q     <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            case (st)
                HS_IDLE: begin
                    second <= 1'b0;
                    if (req && !word_vld) st <= HS_RAISE;
                end
                HS_RAISE: begin
                    if (rdy_s) st <= HS_LOWER;
                end
                HS_LOWER: begin
                    if (!rdy_s) begin
                        if (!second) begin
                            hi_q   <= din;
                            second <= 1'b1;
                            st     <= HS_RAISE;
                        end else begin
                            word     <= join_bytes(hi_q, din);
                            word_vld <= 1'b1;
                            second   <= 1'b0;
                            st       <= HS_IDLE;
                        end
                    end
                end
                default: st <= HS_IDLE;
            endcase
        end
    end

    assign flag = (st == HS_RAISE);
    assign busy = (st != HS_IDLE);
endmodule

// File: rtl/bsl_parser.sv
module bsl_parser
    import boot_ldr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  word_vld,
    input  word_t                 word,
    input  logic                  rdy_s,
    input  logic                  hs_busy,
    output logic                  req,
    output logic                  pre_flag,
    output wr_req_t               wr,
    output logic                  done,
    output logic [BL_ENTRY_W-1:0] entry
);
    localparam word_t ONE_W = word_t'(1);
    localparam addr_t ONE_A = addr_t'(1);

    ps_state_t st;
    word_t     remain;
    word_t     dst_hi;
    addr_t     cur;
    logic      hold_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PS_ENT_HI;
            remain  <= '0;
            dst_hi  <= '0;
            cur     <= '0;
            hold_hi <= 1'b0;
            wr      <= '0;
            done    <= 1'b0;
            entry   <= '0;
        end else begin
            wr.we <= 1'b0;
            done  <= 1'b0;
            if (hs_busy) hold_hi <= 1'b0;
            case (st)
                PS_ENT_HI: if (word_vld) begin
                    entry[BL_ENTRY_W-1:BL_WORD_W] <= word;
                    st <= PS_ENT_LO;
                end
                PS_ENT_LO: if (word_vld) begin
                    entry[BL_WORD_W-1:0] <= word;
                    st <= PS_LEN;
                end
                PS_LEN: if (word_vld) begin
                    if (word == '0) begin
                        done <= 1'b1;
                        st   <= PS_HALT;
                    end else begin
                        remain <= word - ONE_W;
                        st     <= PS_DST_HI;
                    end
                end
                PS_DST_HI: if (word_vld) begin
                    dst_hi <= word;
                    st     <= PS_DST_LO;
                end
                PS_DST_LO: if (word_vld) begin
                    cur <= ext_addr(dst_hi, word);
                    st  <= PS_DATA;
                end
                PS_DATA: if (word_vld) st <= PS_PRE_WR;
                PS_PRE_WR: if (rdy_s) begin
                    wr.we   <= 1'b1;
                    wr.addr <= cur;
                    wr.data <= word;
                    cur     <= cur + ONE_A;
                    hold_hi <= 1'b1;
                    if (remain == '0) begin
                        st <= PS_LEN;
                    end else begin
                        remain <= remain - ONE_W;
                        st     <= PS_DATA;
                    end
                end
                default: st <= PS_HALT;
            endcase
        end
    end

    assign req      = (st != PS_PRE_WR) && (st != PS_HALT);
    assign pre_flag = (st == PS_PRE_WR) || hold_hi;
endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader
    import boot_ldr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_rdy_i,
    input  logic [BL_BYTE_W-1:0]  boot_data_i,
    output logic                  boot_flag_o,
    output logic                  mem_we_o,
    output logic [BL_ADDR_W-1:0]  mem_addr_o,
    output logic [BL_WORD_W-1:0]  mem_data_o,
    output logic                  load_done_o,
    output logic [BL_ENTRY_W-1:0] entry_addr_o
);
    logic    rdy_sync;
    logic    hs_flag;
    logic    hs_busy;
    logic    word_vld;
    word_t   word;
    logic    req;
    logic    pre_flag;
    wr_req_t wr;

    bsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (boot_rdy_i),
        .q   (rdy_sync)
    );

    bsl_word_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rdy_s    (rdy_sync),
        .din      (boot_data_i),
        .flag     (hs_flag),
        .busy     (hs_busy),
        .word_vld (word_vld),
        .word     (word)
    );

    bsl_parser u_parse (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .word     (word),
        .rdy_s    (rdy_sync),
        .hs_busy  (hs_busy),
        .req      (req),
        .pre_flag (pre_flag),
        .wr       (wr),
        .done     (load_done_o),
        .entry    (entry_addr_o)
    );

    assign boot_flag_o = hs_flag | pre_flag;
    assign mem_we_o    = wr.we;
    assign mem_addr_o  = wr.addr;
    assign mem_data_o  = wr.data;
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker (
    input logic clk,
    input logic rst,
    input logic rdy_sync,
    input logic flag,
    input logic mem_we,
    input logic done
);
    AST_FLAG_FALL_ON_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(rdy_sync)); // R1

    AST_WRITE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(rdy_sync) && $past(flag))); // R8

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we); // R4

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_we && !done && !flag)); // R11
endmodule

bind boot_stream_loader bsl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rdy_sync (rdy_sync),
    .flag     (boot_flag_o),
    .mem_we   (mem_we_o),
    .done     (load_done_o)
);

// File: tb/tb_boot_stream_loader.sv
module tb_boot_stream_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rdy = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        flag;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_data;
    logic        done;
    logic [31:0] entry;

    always #10 clk = ~clk;

    boot_stream_loader dut (
        .clk          (clk),
        .rst          (rst),
        .boot_rdy_i   (rdy),
        .boot_data_i  (din),
        .boot_flag_o  (flag),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_data_o   (mem_data),
        .load_done_o  (done),
        .entry_addr_o (entry)
    );

    int n_total = 0;
    int n_pass  = 0;

    logic [7:0]  stream [0:255];
    int          n_bytes;
    logic [19:0] exp_addr [0:63];
    logic [15:0] exp_data [0:63];
    int          exp_n;
    logic [31:0] exp_entry;

    logic [19:0] log_addr [0:63];
    logic [15:0] log_data [0:63];
    int          wr_n;
    int          done_n;
    logic [31:0] done_entry;
    int          rdy_hi;
    logic        prev_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    // Port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                chk(rdy_hi >= 2, "R8 write before ready high", rdy_hi, 2);
                if (wr_n < 64) begin
                    log_addr[wr_n] = mem_addr;
                    log_data[wr_n] = mem_data;
                end
                wr_n++;
            end
            if (prev_flag && !flag)
                chk(rdy_hi >= 2, "R1 flag fell before ready high", rdy_hi, 2);
            if (done) begin
                done_n++;
                done_entry = entry;
            end
        end
        prev_flag = flag;
        rdy_hi = rdy ? rdy_hi + 1 : 0;
    end

    task automatic do_reset();
        rst = 1'b1;
        rdy = 1'b0;
        din = 8'h00;
        repeat (3) @(negedge clk);
        wr_n   = 0;
        done_n = 0;
        done_entry = '0;
        #2 rst = 1'b0;
    endtask

    task automatic push_word(input logic [15:0] w);
        stream[n_bytes]     = w[15:8];
        stream[n_bytes + 1] = w[7:0];
        n_bytes += 2;
    endtask

    task automatic open_stream(input logic [31:0] e);
        n_bytes   = 0;
        exp_n     = 0;
        exp_entry = e;
        push_word(e[31:16]);
        push_word(e[15:0]);
    endtask

    task automatic add_record(input logic [15:0] hi, input logic [15:0] lo, input int len, input int seed);
        logic [31:0] base;
        base = {hi, 16'h0000} + {16'h0000, lo};
        push_word(16'(len));
        push_word(hi);
        push_word(lo);
        for (int k = 0; k < len; k++) begin
            logic [15:0] d;
            d = 16'((seed * 7 + k * 16'h1357) ^ 16'hA5A5);
            if (k == 0) d = 16'h00FF;
            if (k == 1) d = 16'hFF00;
            push_word(d);
            exp_addr[exp_n] = 20'(base + 32'(k));
            exp_data[exp_n] = d;
            exp_n++;
        end
    endtask

    task automatic close_stream();
        push_word(16'h0000);
    endtask

    task automatic feed(input int from, input int upto, input int dly);
        for (int i = from; i < upto; i++) begin
            while (flag !== 1'b1) @(negedge clk);
            repeat (dly) @(negedge clk);
            #2 rdy = 1'b1;
            @(negedge clk);
            while (flag !== 1'b0) @(negedge clk);
            #2;
            din = stream[i];
            rdy = 1'b0;
        end
    endtask

    task automatic finish_and_check(input string name);
        for (int c = 0; c < 60 && done_n == 0; c++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(done_n == 1, {name, " R4 single done pulse"}, done_n, 1);
        chk(done_entry == exp_entry, {name, " R3 entry value"}, done_entry, exp_entry);
        chk(wr_n == exp_n, {name, " R5 write count"}, wr_n, exp_n);
        chk(flag == 1'b0, {name, " R4 flag idle after end"}, flag, 0);
        for (int k = 0; k < exp_n && k < wr_n; k++) begin
            chk(log_addr[k] == exp_addr[k], {name, " R6 R7 write address"}, log_addr[k], exp_addr[k]);
            chk(log_data[k] == exp_data[k], {name, " R2 write data"}, log_data[k], exp_data[k]);
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        rdy = 1'b0;
        repeat (3) @(negedge clk);
        chk(flag == 1'b0,   "R11 flag in reset", flag, 0);
        chk(mem_we == 1'b0, "R11 write strobe in reset", mem_we, 0);
        chk(done == 1'b0,   "R11 done in reset", done, 0);
    endtask

    task automatic t_single_block();
        do_reset();
        open_stream(32'h0012_3456);
        add_record(16'h0001, 16'h2000, 3, 1);
        close_stream();
        feed(0, n_bytes, 0);
        finish_and_check("single");
    endtask

    task automatic t_multi_block();
        do_reset();
        open_stream(32'hCAFE_0042);
        add_record(16'h0000, 16'h0040, 1, 2);
        add_record(16'h0003, 16'hFFFE, 4, 3);
        add_record(16'h0007, 16'h1234, 2, 4);
        close_stream();
        feed(0, n_bytes, 3);
        finish_and_check("multi R9");
    endtask

    task automatic t_empty();
        do_reset();
        open_stream(32'h8000_0001);
        close_stream();
        feed(0, n_bytes, 1);
        finish_and_check("empty R4");
    endtask

    task automatic t_high_addr_bits();
        do_reset();
        open_stream(32'h0000_F000);
        add_record(16'h00F1, 16'h0000, 2, 5);
        close_stream();
        feed(0, n_bytes, 0);
        finish_and_check("truncate R6");
    endtask

    task automatic t_mid_reset();
        do_reset();
        open_stream(32'h1111_2222);
        add_record(16'h0002, 16'h0010, 2, 6);
        close_stream();
        feed(0, 7, 0);
        repeat (5) @(negedge clk);
        do_reset();
        open_stream(32'h3333_4444);
        add_record(16'h0005, 16'h0100, 2, 7);
        close_stream();
        feed(0, n_bytes, 2);
        finish_and_check("midreset R10");
    endtask

    initial begin
        t_reset_state();
        t_single_block();
        t_multi_block();
        t_empty();
        t_high_addr_bits();
        t_mid_reset();
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule